// File: doc/BRIEF.md
# Interval-Gated Phase Difference Counter

This block measures how far a disciplined oscillator lags a once-per-second timing reference. The oscillator is divided by a selectable power of two. On every rising edge of the reference pulse a gate opens. It closes on the first rising edge of the divided oscillator that follows. While the gate is open, every rising edge of a fast counting clock adds one to a 16-bit accumulator. The counting clock is free-running and is deliberately not locked to the oscillator, so its slow drift dithers the ±1-count quantisation. Summing many reference intervals averages that ambiguity away.

Both the reference pulse and the divided oscillator pass through two-flop synchronisers into the counting-clock domain, and their rising edges are detected there. Both paths have the same latency, so it cancels. After every 30th completed interval a one-cycle done pulse is raised. A capture request copies the accumulated total to a parallel result and to a shift register that can be read out serially. The same request clears the accumulator and the interval tally. If no divided edge arrives within a configurable timeout, the gate is forced shut and a sticky overrun flag is set.

Top module: `phase_gate_counter`

## Requirements
- R1: `div_sel_i` = k (0..3) divides the oscillator by 2^(k+1). The compared signal is bit k of a count of oscillator rising edges since reset, so it rises on an oscillator edge where that bit goes from 0 to 1.
- R2: An interval contributes the number of counting-clock rising edges after the first one that samples the reference rise, up to and including the first one that samples the next divided rise. This is zero when both rises are first sampled by the same edge.
- R3: Counts from successive intervals are summed, and `result_o` presents the sum after a capture.
- R4: The accumulator saturates at 16'hFFFF instead of wrapping.
- R5: `done_o` is high for exactly one cycle after the 30th, 60th, … interval ends since the last capture, and is low otherwise.
- R6: On the counting-clock edge that samples `capture_i` high, `result_o` and the shift register load the total, including any count from that same edge. The accumulator and interval tally restart at zero, and `result_o` changes at no other time.
- R7: After a capture, `sdata_o` shows the total MSB first. Each edge with `shift_i` high moves to the next bit, and zeros follow the LSB.
- R8: A gate held open for `TIMEOUT_CYCLES` counts without a divided rise closes and contributes exactly `TIMEOUT_CYCLES`. It sets `overrun_o`, which stays high until a capture.
- R9: When a capture falls on the edge that ends the 30th interval, `done_o` still pulses and the captured total includes that interval's final count.
- R10: After reset, `result_o`, `sdata_o`, `done_o` and `overrun_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running counting clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| osc_clk_i | input | 1 | Oscillator under discipline |
| ref_pps_i | input | 1 | Once-per-second reference pulse, asynchronous |
| div_sel_i | input | 2 | Prescaler select, k gives divide by 2^(k+1) |
| capture_i | input | 1 | Capture request, counting-clock domain |
| shift_i | input | 1 | Advance serial output by one bit |
| result_o | output | 16 | Last captured total |
| sdata_o | output | 1 | Serial output, MSB first |
| done_o | output | 1 | One-cycle pulse after every 30th interval |
| overrun_o | output | 1 | Sticky missing-edge flag |

## Verification
The capture request and the completion of the 30th interval can land on the same counting-clock edge. The bench provokes this by tracking the posedge that samples the divided rise and raising `capture_i` so it is sampled two edges later, exactly when the interval ends. It then expects `done_o` high together with a captured total that includes the final cycle's count. The expected per-interval counts come from a bench model of the prescaler bit and of the posedge that first sees each rise.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  // events leaving the gate controller in one cycle
  typedef struct packed {
    logic close;
    logic overrun;
  } gate_evt_t;

  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/pgc_prescaler.sv
module pgc_prescaler #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             osc_clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             div_o
);
  localparam int unsigned CNT_W = 1 << SEL_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             div_q;

  assign cnt_d = cnt_q + CNT_W'(1);

  // registered tap: select changes cannot glitch the compared signal
  always_ff @(posedge osc_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      div_q <= cnt_d[sel_i];
    end
  end

  assign div_o = div_q;
endmodule

// File: rtl/pgc_sync_edge.sv
module pgc_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;
  logic              prev_q;

  if (STAGES == 1) begin : g_single
    assign stg_d = d_i;
  end else begin : g_chain
    assign stg_d = {stg_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      stg_q  <= stg_d;
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign rise_o = stg_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/pgc_gate.sv
module pgc_gate
  import pgc_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 24_000_000
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ref_rise_i,
  input  logic      div_rise_i,
  input  logic      clear_i,
  output logic      gate_o,
  output gate_evt_t evt_o
);
  localparam int unsigned TMR_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYCLES - 1);

  logic             gate_q, gate_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  gate_evt_t        evt;

  always_comb begin
    gate_d = gate_q;
    tmr_d  = tmr_q;
    evt    = '0;
    if (gate_q) begin
      tmr_d = tmr_q + TMR_W'(1);
      if (div_rise_i) begin
        gate_d    = 1'b0;
        evt.close = 1'b1;
      end else if (tmr_q == TMR_LAST) begin
        gate_d      = 1'b0;
        evt.close   = 1'b1;
        evt.overrun = 1'b1;
      end
    end
    if (ref_rise_i) begin
      tmr_d = '0;
      if (gate_q) begin
        // new reference before any divided edge: end old interval, restart
        evt.close = 1'b1;
        if (!div_rise_i) evt.overrun = 1'b1;
        gate_d = 1'b1;
      end else if (div_rise_i) begin
        // both first seen on one edge: zero-length interval
        evt.close = 1'b1;
        gate_d    = 1'b0;
      end else begin
        gate_d = 1'b1;
      end
    end else if (clear_i) begin
      gate_d = 1'b0;
      tmr_d  = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
      tmr_q  <= '0;
    end else begin
      gate_q <= gate_d;
      tmr_q  <= tmr_d;
    end
  end

  assign gate_o = gate_q;
  assign evt_o  = evt;
endmodule

// File: rtl/pgc_piso.sv
module pgc_piso #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         shift_i,
  output logic         sdata_o
);
  logic [W-1:0] sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sreg_q <= '0;
    else if (load_i)  sreg_q <= data_i;
    else if (shift_i) sreg_q <= {sreg_q[W-2:0], 1'b0};
  end

  assign sdata_o = sreg_q[W-1];
endmodule

// File: rtl/pgc_accum.sv
module pgc_accum
  import pgc_pkg::*;
#(
  parameter int unsigned ACC_W       = 16,
  parameter int unsigned N_INTERVALS = 30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gate_i,
  input  gate_evt_t        evt_i,
  input  logic             capture_i,
  input  logic             shift_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [ACC_W-1:0] result_o,
  output logic             sdata_o,
  output logic             done_o,
  output logic             overrun_o
);
  localparam int unsigned INT_W = (N_INTERVALS > 1) ? $clog2(N_INTERVALS) : 1;
  localparam logic [INT_W-1:0] INT_LAST = INT_W'(N_INTERVALS - 1);

  logic [ACC_W-1:0] acc_q, sum_d, res_q;
  logic [INT_W-1:0] int_q;
  logic             last_iv;
  logic             done_q, ovr_q;

  // saturating add of this cycle's gate count
  assign sum_d   = (gate_i && (acc_q != '1)) ? acc_q + ACC_W'(1) : acc_q;
  assign last_iv = evt_i.close && (int_q == INT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      res_q  <= '0;
      int_q  <= '0;
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      done_q <= last_iv;
      if (capture_i) begin
        res_q <= sum_d;
        acc_q <= '0;
        int_q <= '0;
      end else begin
        acc_q <= sum_d;
        if (evt_i.close) int_q <= last_iv ? '0 : int_q + INT_W'(1);
      end
      if (evt_i.overrun)  ovr_q <= 1'b1;
      else if (capture_i) ovr_q <= 1'b0;
    end
  end

  pgc_piso #(.W(ACC_W)) u_piso (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (capture_i),
    .data_i (sum_d),
    .shift_i(shift_i),
    .sdata_o(sdata_o)
  );

  assign acc_o     = acc_q;
  assign result_o  = res_q;
  assign done_o    = done_q;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/phase_gate_counter.sv
module phase_gate_counter
  import pgc_pkg::*;
#(
  parameter int unsigned SEL_W          = 2,
  parameter int unsigned ACC_W          = 16,
  parameter int unsigned N_INTERVALS    = 30,
  parameter int unsigned TIMEOUT_CYCLES = 24_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             osc_clk_i,
  input  logic             ref_pps_i,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic             capture_i,
  input  logic             shift_i,
  output logic [ACC_W-1:0] result_o,
  output logic             sdata_o,
  output logic             done_o,
  output logic             overrun_o
);
  localparam int unsigned N_SIG = 2;  // 0: reference, 1: divided oscillator

  logic             div_w;
  logic [N_SIG-1:0] raw_w;
  logic [N_SIG-1:0] rise_w;
  logic             gate_w;
  gate_evt_t        evt_w;
  logic [ACC_W-1:0] acc_w;

  pgc_prescaler #(.SEL_W(SEL_W)) u_prescaler (
    .osc_clk_i(osc_clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (div_sel_i),
    .div_o    (div_w)
  );

  assign raw_w = {div_w, ref_pps_i};

  // identical paths so the synchroniser latency cancels in the count
  for (genvar g = 0; g < N_SIG; g++) begin : g_sync
    pgc_sync_edge #(.STAGES(SYNC_DEPTH)) u_sync_edge (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw_w[g]),
      .rise_o(rise_w[g])
    );
  end

  pgc_gate #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ref_rise_i(rise_w[0]),
    .div_rise_i(rise_w[1]),
    .clear_i   (capture_i),
    .gate_o    (gate_w),
    .evt_o     (evt_w)
  );

  pgc_accum #(.ACC_W(ACC_W), .N_INTERVALS(N_INTERVALS)) u_accum (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .gate_i   (gate_w),
    .evt_i    (evt_w),
    .capture_i(capture_i),
    .shift_i  (shift_i),
    .acc_o    (acc_w),
    .result_o (result_o),
    .sdata_o  (sdata_o),
    .done_o   (done_o),
    .overrun_o(overrun_o)
  );
endmodule

// File: rtl/pgc_checker.sv
module pgc_checker #(
  parameter int unsigned ACC_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             capture_i,
  input logic             done_i,
  input logic             overrun_i,
  input logic [ACC_W-1:0] result_i,
  input logic [ACC_W-1:0] acc_i
);
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i); // R5

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(result_i)); // R6

  AST_CLEAR_ON_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> (acc_i == '0)); // R6

  AST_OVERRUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_i && !capture_i) |=> overrun_i); // R8

  AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((acc_i == '1) && !capture_i) |=> (acc_i == '1)); // R4
endmodule

bind phase_gate_counter pgc_checker #(.ACC_W(ACC_W)) u_pgc_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .capture_i(capture_i),
  .done_i   (done_o),
  .overrun_i(overrun_o),
  .result_i (result_o),
  .acc_i    (acc_w)
);

// File: tb/test_phase_gate_counter.sv
module test_phase_gate_counter;
  localparam int ACC_W = 16;
  localparam int TMO   = 3000;
  localparam int NIV   = 30;
  localparam int NVEC  = 6;
  // {div_sel, lead cycles before each reference, intervals per capture}
  localparam int VEC [NVEC][3] = '{
    '{0, 1, 3}, '{1, 4, 2}, '{2, 2, 4}, '{3, 5, 3}, '{3, 1, 1}, '{0, 9, 5}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             osc_clk = 1'b0;
  logic             ref_pps = 1'b0;
  logic [1:0]       div_sel = 2'd0;
  logic             capture = 1'b0;
  logic             shift = 1'b0;
  logic [ACC_W-1:0] result;
  logic             sdata, done, overrun;

  int n_chk = 0;
  int n_bad = 0;
  int pcount = 0;
  int oscn = 0;
  int div_rises = 0;
  int div_pos = 0;
  int done_seen = 0;
  int exp_sum = 0;
  bit div_lvl = 1'b0;
  bit osc_run = 1'b1;

  phase_gate_counter #(.TIMEOUT_CYCLES(TMO)) i_phase_gate_counter (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .osc_clk_i(osc_clk),
    .ref_pps_i(ref_pps),
    .div_sel_i(div_sel),
    .capture_i(capture),
    .shift_i  (shift),
    .result_o (result),
    .sdata_o  (sdata),
    .done_o   (done),
    .overrun_o(overrun)
  );

  always #5 clk = ~clk;

  initial begin
    #3;
    forever begin
      if (osc_run) osc_clk = ~osc_clk;
      #15;
    end
  end

  always @(posedge clk) pcount++;

  // model of R1 prescaler: bit k of oscillator edge count
  always @(posedge osc_clk) begin
    if (rst_n) begin
      bit nl;
      oscn++;
      nl = ((oscn >> div_sel) & 1) != 0;
      if (nl && !div_lvl) begin
        div_rises++;
        div_pos = pcount + 1;
      end
      div_lvl = nl;
    end
  end

  always @(negedge clk) if (done) done_seen++;

  function automatic int sat(input int v);
    return (v > 65535) ? 65535 : v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_cap();
    @(negedge clk) capture = 1'b1;
    @(negedge clk) capture = 1'b0;
  endtask

  task automatic run_iv(input int lead, input bit cap);
    int d0, pr, pd;
    repeat (lead) @(negedge clk);
    d0 = div_rises;
    ref_pps = 1'b1;
    pr = pcount + 1;
    while (div_rises == d0) @(negedge clk);
    pd = div_pos;
    exp_sum = sat(exp_sum + (pd - pr));  // R2
    if (cap) begin
      while (pcount < pd + 1) @(negedge clk);
      capture = 1'b1;
      @(negedge clk);
      capture = 1'b0;
      chk("R9 done with capture", int'(done), 1);
      chk("R9 captured total", int'(result), exp_sum);
    end
    repeat (6) @(negedge clk);
    ref_pps = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_tmo();
    @(negedge clk) ref_pps = 1'b1;
    repeat (5) @(negedge clk);
    ref_pps = 1'b0;
    repeat (TMO + 5) @(negedge clk);
    exp_sum = sat(exp_sum + TMO);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 result after reset", int'(result), 0);
    chk("R10 sdata after reset", int'(sdata), 0);
    chk("R10 done after reset", int'(done), 0);
    chk("R10 overrun after reset", int'(overrun), 0);

    // R1 R2 R3: table of select and phase patterns
    for (int v = 0; v < NVEC; v++) begin
      div_sel = VEC[v][0][1:0];
      repeat (12) @(negedge clk);
      exp_sum = 0;
      for (int n = 0; n < VEC[v][2]; n++) run_iv(VEC[v][1], 1'b0);
      do_cap();
      chk("R1 R2 R3 vector total", int'(result), exp_sum);
    end

    // R6: capture clears
    do_cap();
    chk("R6 second capture empty", int'(result), 0);

    // R5: done after 30th interval only
    div_sel = 2'd2;
    repeat (12) @(negedge clk);
    exp_sum = 0;
    done_seen = 0;
    for (int n = 0; n < NIV - 1; n++) run_iv(3, 1'b0);
    chk("R5 no done before 30th", done_seen, 0);
    run_iv(2, 1'b0);
    chk("R5 done after 30th", done_seen, 1);
    do_cap();
    chk("R3 total of 30 intervals", int'(result), exp_sum);

    // R9: capture on the closing edge of the 30th interval
    div_sel = 2'd1;
    repeat (12) @(negedge clk);
    exp_sum = 0;
    done_seen = 0;
    for (int n = 0; n < NIV - 1; n++) run_iv(2, 1'b0);
    run_iv(2, 1'b1);
    chk("R9 single done pulse", done_seen, 1);

    // R7: serial readout of that capture
    begin
      logic [15:0] w;
      w = '0;
      for (int i = 0; i < 16; i++) begin
        w = {w[14:0], sdata};
        shift = 1'b1;
        @(negedge clk);
      end
      shift = 1'b0;
      chk("R7 serial word", int'(w), exp_sum);
      chk("R7 zero fill", int'(sdata), 0);
    end

    // R8: timeout without divided edge
    chk("R8 overrun clear before timeout", int'(overrun), 0);
    osc_run = 1'b0;
    repeat (10) @(negedge clk);
    exp_sum = 0;
    run_tmo();
    chk("R8 overrun set", int'(overrun), 1);
    do_cap();
    chk("R8 timeout count", int'(result), TMO);
    chk("R8 overrun cleared by capture", int'(overrun), 0);

    // R4: saturation
    exp_sum = 0;
    for (int n = 0; n < 22; n++) run_tmo();
    do_cap();
    chk("R4 saturated total", int'(result), 65535);
    chk("R4 model saturated", exp_sum, 65535);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule